// File: doc/BRIEF.md
# Controllable 16-bit Pseudo-Random Generator

This block holds a 16-bit linear feedback shift register behind a small byte-wide register interface. Software reads the current value as two bytes, writes either byte to seed it, and picks one of four generator modes through a 2-bit control field. The feedback is a left-shifting Galois structure with tap mask 0x8005, which is the polynomial x^16 + x^15 + x^2 + 1.

In run mode, each read of the upper byte returns the current value. On that same clock edge the register moves forward 13 steps through a combinational chain of unrolled steps. A one-shot mode moves the register forward a single step on the clock after the control write, then falls back to run mode by itself. Two further control codes freeze the register. Seed writes have a guard against lock-up: a write that would leave the register at zero loads 0x0001 instead.

Top module: `prng16`

## Requirements
- R1: After reset the state is 0x0001 and the control field reads 00.
- R2: In mode 00, a read strobe at address 1 returns the current upper byte and advances the state by 13 steps on that clock. A step is next = {s[14:0],0} XOR (s[15] ? 0x8005 : 0). A read at address 0 does not change the state.
- R3: Writing 01 to control bits 1:0 at address 2 makes the control field read 01 for exactly one cycle. On the following clock the state advances by exactly one step.
- R4: From the cycle after the single step, the control field reads 00 and normal operation resumes.
- R5: In modes 11 and 10 the state holds, and reads at address 1 do not advance it.
- R6: A write at address 0 replaces the state's low byte and a write at address 1 replaces its high byte. The write takes effect on the clock of the write, in any mode.
- R7: A seed write whose result would be 0x0000 loads 0x0001 instead, so the state is never zero.
- R8: Control write bits 7:2 are ignored and read as 0. Address 3 reads 0x00, and a write to it changes nothing.
- R9: Read data is a combinational function of the address: 0 gives the low byte, 1 the high byte, 2 the control field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe (side effect at address 1) |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, combinational on address |

## Verification
The checks take for granted that read and write strobes are never raised in the same cycle. The stimulus tasks keep to this by driving exactly one strobe at a time, always separated by an idle cycle. The bench sweeps all 256 high-byte seed values, including the all-zero seed, and compares each result against an arithmetic model of the step function. The one-shot sequence is repeated many times, and the control field is observed on the cycle right after the write.

// File: rtl/prng16_pkg.sv
package prng16_pkg;
  typedef enum logic [1:0] {
    MODE_RUN = 2'b00,
    MODE_ONE = 2'b01,
    MODE_RSV = 2'b10,
    MODE_OFF = 2'b11
  } mode_e;

  localparam logic [1:0] ADDR_LO  = 2'd0;
  localparam logic [1:0] ADDR_HI  = 2'd1;
  localparam logic [1:0] ADDR_CTL = 2'd2;
endpackage

// File: rtl/prng16_step.sv
module prng16_step #(
  parameter int          W     = 16,
  parameter logic [W-1:0] POLY = 16'h8005,
  parameter int          STEPS = 13
) (
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STEPS+1];

  assign chain[0] = d_i;

  for (genvar k = 0; k < STEPS; k++) begin : g_step
    assign chain[k+1] = {chain[k][W-2:0], 1'b0} ^ (chain[k][W-1] ? POLY : '0);
  end

  assign q_o = chain[STEPS];
endmodule

// File: rtl/prng16_ctrl.sv
module prng16_ctrl
  import prng16_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ctl_wr_i,
  input  logic [1:0] ctl_wdata_i,
  output mode_e      mode_o
);
  mode_e mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_RUN;
    end else if (ctl_wr_i) begin
      mode_q <= mode_e'(ctl_wdata_i);
    end else if (mode_q == MODE_ONE) begin
      mode_q <= MODE_RUN; // one-shot clears after its step
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/prng16_state.sv
module prng16_state
  import prng16_pkg::*;
#(
  parameter int           W        = 16,
  parameter logic [W-1:0] POLY     = 16'h8005,
  parameter int           UNROLL   = 13,
  parameter logic [W-1:0] RST_SEED = 16'h0001,
  localparam int          HALF     = W / 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  mode_e           mode_i,
  input  logic            adv_i,
  input  logic            lo_wr_i,
  input  logic            hi_wr_i,
  input  logic [HALF-1:0] wdata_i,
  output logic [W-1:0]    state_o
);
  logic [W-1:0] state_q, state_d, multi, single, seed;

  prng16_step #(.W(W), .POLY(POLY), .STEPS(UNROLL)) u_multi (
    .d_i(state_q), .q_o(multi)
  );
  prng16_step #(.W(W), .POLY(POLY), .STEPS(1)) u_single (
    .d_i(state_q), .q_o(single)
  );

  always_comb begin
    seed = state_q;
    if (lo_wr_i) seed = {state_q[W-1:HALF], wdata_i};
    else if (hi_wr_i) seed = {wdata_i, state_q[HALF-1:0]};
  end

  always_comb begin
    state_d = state_q;
    if (lo_wr_i || hi_wr_i) begin
      state_d = (seed == '0) ? W'(1) : seed; // avoid lock-up
    end else if (mode_i == MODE_ONE) begin
      state_d = single;
    end else if (mode_i == MODE_RUN && adv_i) begin
      state_d = multi;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= RST_SEED;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/prng16.sv
module prng16
  import prng16_pkg::*;
#(
  parameter int           W        = 16,
  parameter logic [W-1:0] POLY     = 16'h8005,
  parameter int           UNROLL   = 13,
  parameter logic [W-1:0] RST_SEED = 16'h0001,
  localparam int          HALF     = W / 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_wr_i,
  input  logic            reg_rd_i,
  input  logic [1:0]      reg_addr_i,
  input  logic [HALF-1:0] reg_wdata_i,
  output logic [HALF-1:0] reg_rdata_o
);
  logic [W-1:0] state_q;
  mode_e        mode_q;
  logic         lo_wr, hi_wr, ctl_wr, hi_rd;

  assign lo_wr  = reg_wr_i && reg_addr_i == ADDR_LO;
  assign hi_wr  = reg_wr_i && reg_addr_i == ADDR_HI;
  assign ctl_wr = reg_wr_i && reg_addr_i == ADDR_CTL;
  assign hi_rd  = reg_rd_i && !reg_wr_i && reg_addr_i == ADDR_HI;

  prng16_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctl_wr_i   (ctl_wr),
    .ctl_wdata_i(reg_wdata_i[1:0]),
    .mode_o     (mode_q)
  );

  prng16_state #(
    .W(W), .POLY(POLY), .UNROLL(UNROLL), .RST_SEED(RST_SEED)
  ) u_state (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode_q),
    .adv_i  (hi_rd),
    .lo_wr_i(lo_wr),
    .hi_wr_i(hi_wr),
    .wdata_i(reg_wdata_i),
    .state_o(state_q)
  );

  always_comb begin
    unique case (reg_addr_i)
      ADDR_LO:  reg_rdata_o = state_q[HALF-1:0];
      ADDR_HI:  reg_rdata_o = state_q[W-1:HALF];
      ADDR_CTL: reg_rdata_o = {{(HALF-2){1'b0}}, mode_q};
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/prng16_chk.sv
module prng16_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         reg_wr_i,
  input logic         reg_rd_i,
  input logic [1:0]   reg_addr_i,
  input logic [W-1:0] state_q,
  input logic [1:0]   mode_q
);
  logic seed_wr, ctl_wr, hi_rd;
  assign seed_wr = reg_wr_i && reg_addr_i < 2'd2;
  assign ctl_wr  = reg_wr_i && reg_addr_i == 2'd2;
  assign hi_rd   = reg_rd_i && reg_addr_i == 2'd1;

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_wr_i && reg_rd_i)); // input assumption

  AST_STATE_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0); // R7

  AST_ONESHOT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 2'b01 && !ctl_wr) |=> mode_q == 2'b00); // R4

  AST_STOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q[1] && !seed_wr) |=> $stable(state_q)); // R5

  AST_RUN_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 2'b00 && !hi_rd && !seed_wr) |=> $stable(state_q)); // R2
endmodule

bind prng16 prng16_chk #(.W(W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .reg_wr_i  (reg_wr_i),
  .reg_rd_i  (reg_rd_i),
  .reg_addr_i(reg_addr_i),
  .state_q   (state_q),
  .mode_q    (mode_q)
);

// File: tb/sim_prng16.sv
`timescale 1ns/1ps
module sim_prng16;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic [15:0] m;
  logic [7:0]  d;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  prng16 u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata)
  );

  function automatic logic [15:0] stp(logic [15:0] s);
    return {s[14:0], 1'b0} ^ (s[15] ? 16'h8005 : 16'h0000);
  endfunction

  function automatic logic [15:0] adv(logic [15:0] s, int n);
    logic [15:0] r = s;
    for (int i = 0; i < n; i++) r = stp(r);
    return r;
  endfunction

  function automatic logic [15:0] fix0(logic [15:0] s);
    return (s == 16'h0) ? 16'h0001 : s;
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [1:0] a, logic [7:0] v);
    @(negedge clk);
    addr = a; wdata = v; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic peek(logic [1:0] a, output logic [7:0] v);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic peek_state(string req);
    logic [7:0] lo, hi;
    peek(2'd0, lo);
    peek(2'd1, hi);
    chk(req, {hi, lo}, m);
  endtask

  initial begin
    #(200000 * 10);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m = 16'h0001;
    // R1 reset state
    peek_state("R1");
    peek(2'd2, d); chk("R1", {8'h0, d}, 16'h0);

    // R2/R9 run mode: low read no advance, high read advances 13
    for (int i = 0; i < 300; i++) begin
      rd_reg(2'd0, d); chk("R9", {8'h0, d}, {8'h0, m[7:0]});
      rd_reg(2'd1, d); chk("R2", {8'h0, d}, {8'h0, m[15:8]});
      m = adv(m, 13);
    end
    peek_state("R2");

    // R6/R7 seed sweep over all high bytes
    for (int h = 0; h < 256; h++) begin
      wr_reg(2'd0, 8'(h) ^ 8'h5A);
      m = fix0({m[15:8], 8'(h) ^ 8'h5A});
      wr_reg(2'd1, 8'(h));
      m = fix0({8'(h), m[7:0]});
      peek_state("R6");
      rd_reg(2'd1, d); chk("R2", {8'h0, d}, {8'h0, m[15:8]});
      m = adv(m, 13);
      peek_state("R2");
    end
    wr_reg(2'd0, 8'h00);
    m = fix0({m[15:8], 8'h00});
    wr_reg(2'd1, 8'h00);
    m = fix0({8'h00, m[7:0]});
    peek_state("R7");
    chk("R7", m, 16'h0001);

    // R3/R4 one-shot step
    for (int i = 0; i < 40; i++) begin
      wr_reg(2'd2, 8'h01);
      peek(2'd2, d); chk("R3", {8'h0, d}, 16'h0001);
      @(negedge clk);
      peek(2'd2, d); chk("R4", {8'h0, d}, 16'h0000);
      m = stp(m);
      peek_state("R3");
    end
    rd_reg(2'd1, d); chk("R4", {8'h0, d}, {8'h0, m[15:8]});
    m = adv(m, 13);
    peek_state("R4");

    // R5 stop modes hold under high reads
    wr_reg(2'd2, 8'h03);
    for (int i = 0; i < 5; i++) begin
      rd_reg(2'd1, d); chk("R5", {8'h0, d}, {8'h0, m[15:8]});
    end
    peek_state("R5");
    peek(2'd2, d); chk("R5", {8'h0, d}, 16'h0003);
    wr_reg(2'd2, 8'h02);
    for (int i = 0; i < 5; i++) rd_reg(2'd1, d);
    peek_state("R5");
    wr_reg(2'd0, 8'hAB);
    m = fix0({m[15:8], 8'hAB});
    peek_state("R6");

    // R8 upper control bits ignored, address 3 inert
    wr_reg(2'd2, 8'hFC);
    peek(2'd2, d); chk("R8", {8'h0, d}, 16'h0000);
    wr_reg(2'd2, 8'hFF);
    peek(2'd2, d); chk("R8", {8'h0, d}, 16'h0003);
    wr_reg(2'd3, 8'h55);
    peek_state("R8");
    peek(2'd2, d); chk("R8", {8'h0, d}, 16'h0003);
    peek(2'd3, d); chk("R8", {8'h0, d}, 16'h0000);
    wr_reg(2'd2, 8'h00);
    rd_reg(2'd1, d); chk("R2", {8'h0, d}, {8'h0, m[15:8]});
    m = adv(m, 13);
    peek_state("R2");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule